// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits on the host side of an asynchronous extended-data-out DRAM. It accepts one word request at a time over a valid/ready handshake (a 22-bit word address, a read/write flag and 4 bits of write data), then drives the multiplexed address bus and the active-low row strobe, column strobe, write enable and output enable. The upper address half goes out as the row and the lower half as the column, over the same 11 pins. Every delay is a whole number of clock cycles. Each delay is found by rounding a picosecond parameter up to the next multiple of the clock period.

After an access the row stays open, with the row strobe held low. A later request to the same row is a page hit: only the column strobe toggles. A request to another row first precharges, then opens the new row. Read data is sampled while the column strobe is high again. Extended-data-out parts keep the data valid in that window as long as the row strobe and output enable stay low. A refresh block can force the open row shut through `close_row`. The controller also closes the row on its own before the row strobe would stay low longer than the page-mode limit.

The state machine has eight states. `ST_IDLE` (row closed, ready) goes to `ST_ROW` on accept. `ST_ROW` holds the row address for one cycle and goes to `ST_RCD`. `ST_RCD` (row strobe low) waits out the row-to-column delay and goes to `ST_CSET`. `ST_CSET` sets up the column, write enable and write data for one cycle and goes to `ST_CAS`. `ST_CAS` (column strobe low) lasts its pulse width and goes to `ST_CPRE`. `ST_CPRE` is the column precharge, where reads are sampled, and goes to `ST_OPEN`. `ST_OPEN` (row open, ready) goes to `ST_CSET` on a hit. It goes to `ST_PRE` on a miss, on `close_row`, or when the row-time guard expires. `ST_PRE` holds the row strobe high for the precharge time. It then goes to `ST_ROW` if a miss request is pending, and otherwise to `ST_IDLE`.

Top module: `edo_page_ctrl`

## Requirements
- R1: Out of reset, all four strobes are high, `dram_dq_oe` is 0, `req_ready` is 1 and `rdata_valid` is 0.
- R2: The row address is `req_addr[21:11]`, present on `dram_addr` when the row strobe falls. The column address is `req_addr[10:0]`, present when the column strobe falls. The address is held steady while the column strobe is low.
- R3: A read returns the last data written to that address, or 0 if the address was never written. `rdata_valid` is a single-cycle pulse that comes one cycle after the sample point, once per read.
- R4: A write is an early write. Write enable goes low at least one cycle before the column strobe falls. `dram_dq_oe` is 1 with the write data while the column strobe is low, and output enable stays high whenever `dram_dq_oe` is 1.
- R5: A request accepted while the row is open and to the same row is a page hit. It causes no row-strobe activity, and its read data is valid 1 + CAS_CYC + CP_CYC cycles after the accepting edge.
- R6: A request accepted while the row is closed gives read data 1 + RCD_CYC + 1 + CAS_CYC + CP_CYC cycles after the accepting edge.
- R7: A request to a different row while a row is open precharges with the row strobe high for at least RP_CYC cycles, then opens the new row. Its read data comes RP_CYC cycles later than in R6.
- R8: While `close_row` is 1 in the open state, `req_ready` is 0 and the row closes on the next edge. The row strobe only rises while the column strobe is high.
- R9: The row strobe never stays low for more than RASP_CYC cycles. A long run of page hits is broken by a precharge, and the row is reopened.
- R10: Each column-strobe low pulse lasts at least CAS_CYC cycles. Within one row cycle, the column strobe stays high for at least CP_CYC cycles between low pulses.
- R11: Read data is sampled while the column strobe is high, with the row strobe and output enable still low.
- R12: `req_ready` is 0 on the cycle right after a request is accepted, and stays 0 until the block is back in the idle or open state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in bits 21:11, column in bits 10:0 |
| req_wdata | input | 4 | Write data |
| close_row | input | 1 | Force the open row closed (refresh hook) |
| rdata | output | 4 | Read data |
| rdata_valid | output | 1 | One-cycle read-data strobe |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
The address patterns exercise the three row states: a closed row, a hit on the open row, and a miss to another row. The read latency measured from the accepting edge tells these cases apart (R5, R6, R7). Row and column values use all-ones, zero and mixed bit patterns, so a swapped or shifted address half shows up in the model's latched row and column. The bench model drives read data only while the column strobe is high, so sampling too early returns unknown data. A long stream of same-row hits, and a `close_row` pulse, show that the row is closed and reopened and that the next access is priced as a closed-row access.

// File: rtl/edo_pkg.sv
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_CSET,
        ST_CAS,
        ST_CPRE,
        ST_OPEN,
        ST_PRE
    } edo_state_e;

    // Round a duration in picoseconds up to whole clock cycles, at least one.
    function automatic int unsigned ps_to_cycles(input int unsigned dur_ps,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (dur_ps + clk_ps - 1) / clk_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // A load of N keeps done low for N-1 cycles, so a state lasts N cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val - 1'b1;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R10: every timed phase lasts at least one cycle.
    p_load_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/edo_row_track.sv
module edo_row_track #(
    parameter int ROW_W    = 11,
    parameter int RASP_CYC = 10000,
    parameter int GUARD    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_load,
    input  logic [ROW_W-1:0] open_row_in,
    input  logic             close,
    input  logic             ras_low,
    input  logic [ROW_W-1:0] req_row,
    output logic             hit,
    output logic             expired
);
    localparam int CW    = $clog2(RASP_CYC + 1);
    localparam int LIMIT = RASP_CYC - GUARD - 1;

    logic [ROW_W-1:0] row_q;
    logic             open_q;
    logic [CW-1:0]    ras_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            open_q <= 1'b0;
        end else if (close) begin
            open_q <= 1'b0;
        end else if (open_load) begin
            row_q  <= open_row_in;
            open_q <= 1'b1;
        end
    end

    // Cycles completed with the row strobe low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ras_cnt <= '0;
        else if (!ras_low) ras_cnt <= '0;
        else               ras_cnt <= ras_cnt + 1'b1;
    end

    assign hit     = open_q && (row_q == req_row);
    assign expired = (ras_cnt >= CW'(LIMIT));

    // R9: the row strobe low time stays inside the page-mode window.
    p_ras_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ras_cnt <= CW'(RASP_CYC));

    // R7: the open flag does not outlive a precharge.
    p_open_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !ras_low && close) |=> !open_q);

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int ROW_W     = 11,
    parameter int DQ_W      = 4,
    parameter int CLK_PS    = 10000,
    parameter int T_RP_PS   = 40000,
    parameter int T_RCD_PS  = 30000,
    parameter int T_CAS_PS  = 10000,
    parameter int T_CP_PS   = 10000,
    parameter int T_RASP_PS = 100000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic              close_row,
    output logic [DQ_W-1:0]   rdata,
    output logic              rdata_valid,
    output logic [10:0]       dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    localparam int COL_W    = ADDR_W - ROW_W;
    localparam int RP_CYC   = int'(ps_to_cycles(T_RP_PS,   CLK_PS));
    localparam int RCD_CYC  = int'(ps_to_cycles(T_RCD_PS,  CLK_PS));
    localparam int CAS_CYC  = int'(ps_to_cycles(T_CAS_PS,  CLK_PS));
    localparam int CP_CYC   = int'(ps_to_cycles(T_CP_PS,   CLK_PS));
    localparam int RASP_CYC = int'(ps_to_cycles(T_RASP_PS, CLK_PS));
    localparam int PAGE_CYC = 1 + CAS_CYC + CP_CYC;
    localparam int TMAX_A   = (RP_CYC  > RCD_CYC) ? RP_CYC  : RCD_CYC;
    localparam int TMAX_B   = (CAS_CYC > CP_CYC)  ? CAS_CYC : CP_CYC;
    localparam int TMAX     = (TMAX_A  > TMAX_B)  ? TMAX_A  : TMAX_B;
    localparam int TW       = $clog2(TMAX + 1);

    edo_state_e state, nxt;

    logic             wr_q, pend_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [DQ_W-1:0]  wdata_q;
    logic             accept, hit, expired, t_done, t_load;
    logic [TW-1:0]    t_val;

    assign accept = req_valid && req_ready;

    edo_phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
    );

    edo_row_track #(.ROW_W(ROW_W), .RASP_CYC(RASP_CYC), .GUARD(PAGE_CYC)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .open_load(state == ST_ROW), .open_row_in(row_q),
        .close(state == ST_PRE), .ras_low(!dram_ras_n),
        .req_row(req_addr[ADDR_W-1:COL_W]),
        .hit(hit), .expired(expired)
    );

    // Ready in the two waiting states only.
    always_comb begin
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_OPEN: req_ready = !close_row && !expired;
            default: req_ready = 1'b0;
        endcase
    end

    // Next-state decode.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept) nxt = ST_ROW;
            ST_ROW:  nxt = ST_RCD;
            ST_RCD:  if (t_done) nxt = ST_CSET;
            ST_CSET: nxt = ST_CAS;
            ST_CAS:  if (t_done) nxt = ST_CPRE;
            ST_CPRE: if (t_done) nxt = ST_OPEN;
            ST_OPEN: begin
                if (accept)                     nxt = hit ? ST_CSET : ST_PRE;
                else if (close_row || expired)  nxt = ST_PRE;
            end
            ST_PRE:  if (t_done) nxt = pend_q ? ST_ROW : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Timer reload on entry to a timed state.
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (nxt != state) begin
            unique case (nxt)
                ST_RCD:  begin t_load = 1'b1; t_val = TW'(RCD_CYC); end
                ST_CAS:  begin t_load = 1'b1; t_val = TW'(CAS_CYC); end
                ST_CPRE: begin t_load = 1'b1; t_val = TW'(CP_CYC);  end
                ST_PRE:  begin t_load = 1'b1; t_val = TW'(RP_CYC);  end
                default: ;
            endcase
        end
    end

    // State register and request capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wr_q    <= 1'b0;
            pend_q  <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                wr_q    <= req_write;
                row_q   <= req_addr[ADDR_W-1:COL_W];
                col_q   <= req_addr[COL_W-1:0];
                wdata_q <= req_wdata;
            end
            if (accept && state == ST_OPEN && !hit) pend_q <= 1'b1;
            else if (state == ST_PRE && t_done)     pend_q <= 1'b0;
        end
    end

    // Read sample at the close of column precharge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= (state == ST_CPRE) && t_done && !wr_q;
            if ((state == ST_CPRE) && t_done && !wr_q) rdata <= dram_dq_in;
        end
    end

    // Strobe decode.
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_cas_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_addr   = 11'(row_q);
        dram_dq_out = wdata_q;
        unique case (state)
            ST_IDLE, ST_ROW, ST_PRE: ;
            ST_RCD:  dram_ras_n = 1'b0;
            ST_CSET, ST_CAS: begin
                dram_ras_n = 1'b0;
                dram_cas_n = (state != ST_CAS);
                dram_addr  = 11'(col_q);
                dram_we_n  = !wr_q;
                dram_oe_n  = wr_q;
                dram_dq_oe = wr_q;
            end
            ST_CPRE: begin
                dram_ras_n = 1'b0;
                dram_addr  = 11'(col_q);
                dram_oe_n  = wr_q;
            end
            ST_OPEN: begin
                dram_ras_n = 1'b0;
                dram_addr  = 11'(col_q);
            end
            default: ;
        endcase
    end

    // R3: read strobe is a single-cycle pulse.
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);

    // R4: write enable already low on the cycle before the column strobe falls.
    p_early_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0));

    // R4: never drive the data pins while the DRAM may drive them.
    p_bus_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n);

    // R8: the row strobe only rises with the column strobe already high.
    p_cycle_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> dram_cas_n);

    // R2: the column address holds while the column strobe is low.
    p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

endmodule

// File: tb/sim_edo_page_ctrl.sv
`timescale 1ns/1ps
module sim_edo_page_ctrl;
    localparam int RP = 4, RCD = 3, CASW = 1, CP = 1, RASP = 30;
    localparam int HIT = 1 + CASW + CP;
    localparam int CLOSED = 1 + RCD + 1 + CASW + CP;
    localparam int MISS = RP + CLOSED;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, close_row = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0] req_wdata = '0;
    logic req_ready, rdata_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0] rdata, dram_dq_out, dram_dq_in;
    logic [10:0] dram_addr;

    always #5 clk = ~clk;

    edo_page_ctrl #(.T_RASP_PS(300000)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .close_row(close_row), .rdata(rdata), .rdata_valid(rdata_valid),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0, errors = 0, cyc = 0, ras_falls = 0;
    logic [10:0] last_row = '0, exp_row = '0, exp_col = '0;
    logic [3:0] rmem [logic [21:0]];
    logic [3:0] dmem [logic [21:0]];
    logic [3:0] q_dat[$];
    int q_lat[$], q_acc[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural DRAM: latches on strobe edges, holds read data after CAS rises.
    logic m_pras = 1'b1, m_pcas = 1'b1, m_pwe = 1'b1, m_have = 1'b0;
    logic [10:0] m_row = '0, m_col = '0;
    logic [3:0] m_dat = '0;
    int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000;
    always @(negedge clk) begin
        if (m_pras && !dram_ras_n) begin
            m_row = dram_addr;
            ras_falls++;
            check(ras_hi >= RP, "R7 precharge width", ras_hi, RP);
            check(m_row == exp_row, "R2 row", m_row, exp_row);
            cas_hi = 0;
        end
        if (!m_pras && dram_ras_n) begin
            check(ras_lo <= RASP, "R9 ras low time", ras_lo, RASP);
            check(dram_cas_n == 1'b1, "R8 cas high at ras rise", dram_cas_n, 1);
        end
        if (m_pcas && !dram_cas_n) begin
            m_col = dram_addr;
            check(m_col == exp_col, "R2 column", m_col, exp_col);
            if (cas_hi < 1000 && ras_lo > 0 && !m_pras)
                check(cas_hi >= CP, "R10 cas precharge", cas_hi, CP);
            if (!dram_we_n) begin
                check(!m_pwe, "R4 we before cas", m_pwe, 0);
                check(dram_dq_oe && dram_oe_n, "R4 drive/oe", {dram_dq_oe, dram_oe_n}, 3);
                dmem[{m_row, m_col}] = dram_dq_oe ? dram_dq_out : 4'bx;
                m_have = 1'b0;
            end else begin
                m_dat  = dmem.exists({m_row, m_col}) ? dmem[{m_row, m_col}] : 4'h0;
                m_have = 1'b1;
            end
        end
        if (!m_pcas && dram_cas_n) check(cas_lo >= CASW, "R10 cas width", cas_lo, CASW);
        if (dram_ras_n) m_have = 1'b0;
        dram_dq_in = (m_have && dram_cas_n && !dram_ras_n && !dram_oe_n) ? m_dat : 4'bx;
        ras_lo = dram_ras_n ? 0 : ras_lo + 1;
        ras_hi = dram_ras_n ? ras_hi + 1 : 0;
        cas_lo = dram_cas_n ? 0 : cas_lo + 1;
        cas_hi = dram_cas_n ? cas_hi + 1 : 0;
        m_pras = dram_ras_n; m_pcas = dram_cas_n; m_pwe = dram_we_n;
    end

    // Read-data monitor against the reference queue.
    always @(negedge clk) begin
        if (rst_n && rdata_valid) begin
            if (q_dat.size() == 0) begin
                check(1'b0, "R3 unexpected rdata_valid", 1, 0);
            end else begin
                automatic logic [3:0] d = q_dat.pop_front();
                automatic int l = q_lat.pop_front();
                automatic int a = q_acc.pop_front();
                check(rdata === d, "R3/R11 read data", rdata, d);
                check(cyc - a == l, l == HIT ? "R5 hit latency" :
                      (l == MISS ? "R7 miss latency" : "R6 closed latency"), cyc - a, l);
            end
        end
    end

    task automatic issue(input bit wr, input logic [21:0] a, input logic [3:0] d);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        lat = dram_ras_n ? CLOSED : ((a[21:11] == last_row) ? HIT : MISS);
        if (lat == HIT) check(1'b1, "R5 hit keeps row", 0, 0);
        last_row = a[21:11]; exp_row = a[21:11]; exp_col = a[10:0];
        if (wr) rmem[a] = d;
        else begin
            q_dat.push_back(rmem.exists(a) ? rmem[a] : 4'h0);
            q_lat.push_back(lat);
            q_acc.push_back(cyc + 1);
        end
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b0, "R12 busy after accept", req_ready, 0);
    endtask

    task automatic drain();
        while (q_dat.size() != 0) @(negedge clk);
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        logic [21:0] A, B, C, D;
        A = {11'h123, 11'h005}; B = {11'h123, 11'h7FF};
        C = {11'h4AA, 11'h000}; D = {11'h7FF, 11'h3C3};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hF, "R1 strobes", dram_ras_n, 1);
        check(req_ready && !rdata_valid && !dram_dq_oe, "R1 handshake", req_ready, 1);
        rst_n = 1'b1;

        issue(1, A, 4'hA);  issue(0, A, 0);
        issue(1, B, 4'h5);  issue(0, B, 0);  issue(0, A, 0);
        issue(1, C, 4'h3);  issue(0, A, 0);  issue(0, C, 0);
        issue(0, D, 0);     issue(1, D, 4'hF); issue(0, D, 0);
        drain();

        // Forced close of the open row.
        @(negedge clk);
        check(dram_ras_n == 1'b0, "R8 row open before close", dram_ras_n, 0);
        close_row = 1'b1;
        #1 check(req_ready == 1'b0, "R8 ready low on close", req_ready, 0);
        @(posedge clk); #1 close_row = 1'b0;
        @(negedge clk);
        check(dram_ras_n && dram_cas_n, "R8 row closed", dram_ras_n, 1);
        issue(0, C, 0);
        drain();

        // Long same-row stream must be split by the RAS-low limit.
        f0 = ras_falls;
        for (int i = 0; i < 10; i++) begin
            issue(1, {11'h2B1, 11'(i * 37)}, 4'(i + 3));
            issue(0, {11'h2B1, 11'(i * 37)}, 0);
        end
        drain();
        check(ras_falls - f0 >= 2, "R9 row reopened", ras_falls - f0, 2);
        issue(0, {11'h001, 11'h001}, 0);
        drain();
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule